// File: doc/BRIEF.md
# Power-Fail Write-Protect Gate

This block sits between a parallel byte-wide bus and a battery-backed static RAM. It decides, cycle by cycle, whether bus strobes may reach the memory. While the supply is healthy, the chip-select, write and read strobes, the address and the write data pass straight through. Read data comes back onto the bus whenever a read is under way.

A digitised comparator bit reports whether the supply is above the fail threshold. A drop is treated as real only after the bit has stayed low for `FALL_CYC` consecutive clock samples, so shorter spikes are ignored. Once a drop is qualified, the memory is deselected and all writes are blocked at once, which can cut off a write that is already in progress. The bus-side data driver is switched off, and address and write data towards the memory are forced to zero. Access returns only after the comparator has stayed high for `REC_CYC` consecutive samples.

A second comparator bit, for the lower switchover level, drives a registered select output that chooses between the battery and the external supply. Both count limits must be at least 2.

Top module: `pfail_access_gate`

## Requirements
- R1: While access is enabled, mem_ce_n_o, mem_we_n_o and mem_oe_n_o equal ce_n_i, we_n_i and oe_n_i, mem_addr_o equals addr_i, and mem_wdata_o equals wdata_i, all in the same cycle.
- R2: While protected, mem_ce_n_o, mem_we_n_o and mem_oe_n_o are all 1, whatever the bus strobes do.
- R3: dq_oe_o is 1 only when access is enabled, ce_n_i=0, oe_n_i=0 and we_n_i=1. In that case dq_o equals mem_rdata_i. Otherwise dq_o is 0. While protected, mem_addr_o and mem_wdata_o are 0.
- R4: A write strobe that is active while pwr_ok_i is low but not yet qualified still reaches the memory. It is cut off in the cycle right after the qualifying clock edge.
- R5: pwr_ok_i low for fewer than FALL_CYC consecutive clock edges leaves access enabled. Low for FALL_CYC consecutive edges makes the block protected right after the FALL_CYC-th edge.
- R6: bat_sel_o (1 = battery, 0 = external supply) takes the inverse of above_sw_i sampled at the previous clock edge.
- R7: When protected, access is re-enabled right after the REC_CYC-th consecutive clock edge with pwr_ok_i high. Any low sample restarts that count.
- R8: Asynchronous active-low reset puts the block in the protected state with bat_sel_o = 0. After reset the recovery count of R7 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Supply above fail threshold (1 = good) |
| above_sw_i | input | 1 | Supply above switchover level |
| ce_n_i | input | 1 | Bus chip select, active low |
| we_n_i | input | 1 | Bus write strobe, active low |
| oe_n_i | input | 1 | Bus output enable, active low |
| addr_i | input | AW | Bus address |
| wdata_i | input | DW | Bus write data |
| dq_o | output | DW | Read data towards the bus |
| dq_oe_o | output | 1 | Bus data driver enable (0 = high impedance) |
| mem_ce_n_o | output | 1 | Memory chip select, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_addr_o | output | AW | Memory address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data |
| bat_sel_o | output | 1 | Power source select, 1 = battery |

## Verification
Two functions can fall in the same cycle: the qualification of a power failure and a write strobe that is already asserted. The bench holds a write active while pwr_ok_i goes low. It checks that mem_we_n_o still follows the strobe after FALL_CYC-1 low edges, and that mem_we_n_o, dq_oe_o and the address are blocked right after the next edge. A second collision, a comparator bounce in the middle of recovery, is provoked by dropping pwr_ok_i partway through the hold-off. The bench then checks that the full REC_CYC count restarts from zero.

// File: rtl/pfail_access_gate.sv
module pfail_access_gate #(
  parameter int AW       = 19,
  parameter int DW       = 8,
  parameter int FALL_CYC = 4,
  parameter int REC_CYC  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_ok_i,
  input  logic          above_sw_i,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic          mem_ce_n_o,
  output logic          mem_we_n_o,
  output logic          mem_oe_n_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          bat_sel_o
);

  localparam int MAXC = (FALL_CYC > REC_CYC) ? FALL_CYC : REC_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FALL_LAST = CW'(FALL_CYC - 1);
  localparam logic [CW-1:0] REC_LAST  = CW'(REC_CYC - 1);

  logic          act;
  logic [CW-1:0] cnt;

  initial begin
    a_r5_r7_limits: assert (FALL_CYC >= 2 && REC_CYC >= 2)
      else $error("count limits must be at least 2");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (act) begin
      if (pwr_ok_i)                cnt <= '0;
      else if (cnt == FALL_LAST) begin
        act <= 1'b0;
        cnt <= '0;
      end else                     cnt <= cnt + 1'b1;
    end else begin
      if (!pwr_ok_i)               cnt <= '0;
      else if (cnt == REC_LAST) begin
        act <= 1'b1;
        cnt <= '0;
      end else                     cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bat_sel_o <= 1'b0;
    else        bat_sel_o <= ~above_sw_i;
  end

  assign mem_ce_n_o  = ce_n_i | ~act;
  assign mem_we_n_o  = we_n_i | ~act;
  assign mem_oe_n_o  = oe_n_i | ~act;
  assign mem_addr_o  = act ? addr_i  : '0;
  assign mem_wdata_o = act ? wdata_i : '0;
  assign dq_oe_o     = act & ~ce_n_i & ~oe_n_i & we_n_i;
  assign dq_o        = dq_oe_o ? mem_rdata_i : '0;

  a_r5_glitch_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(act) && $past(pwr_ok_i) |-> act);

  a_r7_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act) && !$past(pwr_ok_i) |-> !act);

  a_r2_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(act) && !act |-> mem_we_n_o && mem_ce_n_o);

  a_r3_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !dq_oe_o && dq_o == '0);

endmodule

// File: tb/pfail_access_gate_bench.sv
`timescale 1ns/100ps
module pfail_access_gate_bench;
  localparam int AW = 19, DW = 8, FALL = 4, REC = 8;

  logic clk = 0, rst_n = 0;
  logic pwr_ok = 1, above_sw = 1, ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata = 8'hA5;
  logic [DW-1:0] dq;
  logic dq_oe, mce_n, mwe_n, moe_n, bat;
  logic [AW-1:0] maddr;
  logic [DW-1:0] mwdata;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  pfail_access_gate #(.AW(AW), .DW(DW), .FALL_CYC(FALL), .REC_CYC(REC)) u_pfail_access_gate (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .above_sw_i(above_sw),
    .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n), .addr_i(addr), .wdata_i(wdata),
    .dq_o(dq), .dq_oe_o(dq_oe), .mem_ce_n_o(mce_n), .mem_we_n_o(mwe_n),
    .mem_oe_n_o(moe_n), .mem_addr_o(maddr), .mem_wdata_o(mwdata),
    .mem_rdata_i(rdata), .bat_sel_o(bat));

  // {mce,mwe,moe,doe, ce,we,oe}
  localparam logic [6:0] VEC [6] = '{
    7'b0101_010, 7'b0010_001, 7'b1100_110,
    7'b0110_011, 7'b0000_000, 7'b1110_111};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  initial begin
    #100000;
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    ce_n = 0; we_n = 0; oe_n = 1; addr = 19'h12345; wdata = 8'h3C;
    tick(2);
    // R8: reset protects, battery not selected
    chk("R8 mem_we_n in reset", mwe_n, 1);
    chk("R8 mem_ce_n in reset", mce_n, 1);
    chk("R8 bat_sel in reset", bat, 0);
    chk("R3 addr zero in reset", maddr, 0);
    ce_n = 1; we_n = 1;
    rst_n = 1;
    ce_n = 0; oe_n = 0;
    tick(REC - 1);
    chk("R7 still protected after REC-1", mce_n, 1);
    tick(1);
    chk("R7 enabled after REC", mce_n, 0);
    chk("R3 read data", dq, 8'hA5);

    // R1/R3 pass-through table
    for (int i = 0; i < 6; i++) begin
      {ce_n, we_n, oe_n} = VEC[i][2:0];
      addr = AW'(19'h40000 + i); wdata = 8'(8'h10 + i);
      #1;
      chk("R1 mem_ce_n", mce_n, VEC[i][6]);
      chk("R1 mem_we_n", mwe_n, VEC[i][5]);
      chk("R1 mem_oe_n", moe_n, VEC[i][4]);
      chk("R3 dq_oe", dq_oe, VEC[i][3]);
      chk("R3 dq", dq, VEC[i][3] ? 8'hA5 : 8'h00);
      chk("R1 addr", maddr, addr);
      chk("R1 wdata", mwdata, wdata);
    end

    // R5 glitch of FALL-1 samples is ignored
    ce_n = 0; we_n = 1; oe_n = 0;
    pwr_ok = 0; tick(FALL - 1);
    pwr_ok = 1; tick(1);
    chk("R5 glitch ignored ce", mce_n, 0);
    chk("R5 glitch ignored dq_oe", dq_oe, 1);
    tick(3);

    // R4/R2: write in progress at qualification
    ce_n = 0; we_n = 0; oe_n = 1; addr = 19'h00777; wdata = 8'h5A;
    pwr_ok = 0; tick(FALL - 1);
    chk("R4 write passes before qualify", mwe_n, 0);
    chk("R4 addr passes before qualify", maddr, 19'h00777);
    tick(1);
    chk("R4 write cut at qualify", mwe_n, 1);
    chk("R2 ce blocked", mce_n, 1);
    chk("R3 addr zero protected", maddr, 0);
    chk("R3 wdata zero protected", mwdata, 0);
    // R2: strobes ignored while protected
    we_n = 1; oe_n = 0; #1;
    chk("R3 no drive protected", dq_oe, 0);
    chk("R2 oe blocked", moe_n, 1);
    we_n = 0; addr = 19'h7FFF8; tick(2);
    chk("R2 later write blocked", mwe_n, 1);

    // R7 bounce restarts recovery
    we_n = 1; oe_n = 1;
    pwr_ok = 1; tick(REC - 3);
    pwr_ok = 0; tick(1);
    pwr_ok = 1; tick(REC - 1);
    chk("R7 restart after bounce", mce_n, 1);
    tick(1);
    chk("R7 enabled after full count", mce_n, 0);

    // R6 battery select
    above_sw = 0; #1;
    chk("R6 not yet switched", bat, 0);
    tick(1);
    chk("R6 battery selected", bat, 1);
    above_sw = 1; tick(1);
    chk("R6 back to supply", bat, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule